// File: doc/BRIEF.md
# Indexed Block-Transfer Register Target for a Two-Wire Serial Bus

This block is a target on a two-wire, open-drain serial bus with a clock line and a data line, as used for SMBus configuration traffic. It holds a small bank of 8-bit configuration registers, and their contents are presented continuously as a flat parallel output. The two bus lines are brought into the system clock domain through synchronizers. All bus events are recovered there: start, repeated start, stop, and the rising and falling edges of the clock line.

A host writes to the bank as follows. It sends the write address, a starting register index and a byte count, followed by that many data bytes. These data bytes land in consecutive registers.

To read, the host first sets the index with a short write. It then issues a repeated start and the read address. The target replies with a count byte, taken from a dedicated register in the bank that the host can write. After the count byte come the register contents in ascending index order, until the host answers a byte with a not-acknowledge. The data line is only ever pulled low through an enable, and it is never driven high.

Top module: `smb_blk_regs`

## Requirements
- R1: The target acknowledges the address byte 0xD4 (7-bit address 0x6A with bit 0 = 0, write) and the address byte 0xD5 (bit 0 = 1, read). Any other address byte gets no acknowledge, and the target then leaves the data line released for all following bytes until the next start condition.
- R2: In a write, the target acknowledges the index byte N, the count byte X and each data byte, one acknowledge per byte. The X data bytes are stored in registers N, N+1, and so on up to N+X-1. A register output changes only after a falling edge of the bus clock.
- R3: Data bytes sent beyond the X-th are acknowledged but stored nowhere.
- R4: After the last register (index NREGS-1 = 7), the index wraps to 0. An index of NREGS or above addresses no register: writes to it are acknowledged and discarded, reads from it return 0x00, and from there the index counts upward without wrapping.
- R5: After a repeated start and the address byte 0xD5, the target first sends the value of the count register (index 7). It then sends the registers starting at the index N set by the preceding write, in increasing order, with the most significant bit first.
- R6: A not-acknowledge from the host ends the read. The target releases the data line and drives nothing more until the next start.
- R7: A start or stop condition at any point aborts the transfer in progress and restarts the bit counter. A partly received byte is discarded.
- R8: The data-line enable changes only while the bus clock is low.
- R9: Under reset, all registers read 0x00 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | When high, the data line is pulled low |
| regs_o | output | NREGS*8 | Register bank; register i occupies bits [8i+7:8i] |

## Verification
The hardest situation to create is an abort in the middle of a byte. A start or stop must arrive after only a few data bits, while the target is already primed to store data. The bench reaches this by clocking out a partial byte with a bit-level task and then issuing a repeated start or a stop on the lines. After that it runs a complete transfer and checks that the partial byte never reached the bank. Index wrap and out-of-bank indices are covered by sweeping the starting index past the end of the bank, for both writes and reads.

// File: rtl/smb_blk_regs.sv
module smb_blk_regs #(
  parameter int         NREGS    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         CNT_IDX  = NREGS - 1,
  parameter int         SYNC     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_IDX, K_CNT, K_DATA} kind_t;

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_c, stop_c, scl_rise, scl_fall;

  st_t   st;
  kind_t kind;
  logic [3:0] bcnt;
  logic [7:0] sh, tx, ptr, left, rd_byte;
  logic rd, hack, oe;
  logic [7:0] regs [NREGS];

  assign scl_s    = scl_sy[SYNC-1];
  assign sda_s    = sda_sy[SYNC-1];
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign sda_oe   = oe;
  assign rd_byte  = (ptr < 8'(NREGS)) ? regs[ptr[AW-1:0]] : 8'h00;

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end

  function automatic logic [7:0] nxt(input logic [7:0] i);
    return (i == 8'(NREGS - 1)) ? 8'd0 : i + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      st     <= S_IDLE;
      kind   <= K_ADDR;
      bcnt   <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      left   <= '0;
      rd     <= 1'b0;
      hack   <= 1'b0;
      oe     <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (start_c) begin
        st   <= S_RX;
        kind <= K_ADDR;
        bcnt <= '0;
        oe   <= 1'b0;
      end else if (stop_c) begin
        st   <= S_IDLE;
        bcnt <= '0;
        oe   <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bcnt < 4'd8) begin
              sh   <= {sh[6:0], sda_s};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              st   <= S_ACK;
              oe   <= 1'b1;
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    rd   <= sh[0];
                    kind <= K_IDX;
                  end else begin
                    st <= S_IDLE;
                    oe <= 1'b0;
                  end
                end
                K_IDX: begin
                  ptr  <= sh;
                  kind <= K_CNT;
                end
                K_CNT: begin
                  left <= sh;
                  kind <= K_DATA;
                end
                default: begin
                  if (left != 8'd0) begin
                    if (ptr < 8'(NREGS)) regs[ptr[AW-1:0]] <= sh;
                    ptr  <= nxt(ptr);
                    left <= left - 8'd1;
                  end
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (rd) begin
                st <= S_TX;
                oe <= ~regs[CNT_IDX][7];
                tx <= {regs[CNT_IDX][6:0], 1'b0};
              end else begin
                st <= S_RX;
                oe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall) begin
              if (bcnt == 4'd8) begin
                oe   <= 1'b0;
                bcnt <= '0;
                st   <= S_TXACK;
              end else begin
                oe <= ~tx[7];
                tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              hack <= ~sda_s;
            end else if (scl_fall) begin
              if (hack) begin
                st  <= S_TX;
                oe  <= ~rd_byte[7];
                tx  <= {rd_byte[6:0], 1'b0};
                ptr <= nxt(ptr);
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module smb_blk_regs_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         start_c,
  input logic         stop_c,
  input logic         scl_fall,
  input logic         sda_oe,
  input logic [W-1:0] regs_o
);
  assert_oe_rise_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_release_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);
  assert_release_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
  assert_reg_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(scl_fall));
endmodule

bind smb_blk_regs smb_blk_regs_chk #(.W(NREGS*8)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_c(start_c), .stop_c(stop_c),
  .scl_fall(scl_fall), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/smb_blk_regs_tb.sv
module smb_blk_regs_tb_top;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam int NR    = 8;
  localparam int CI    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  wire  sda_line = sda_h & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  smb_blk_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  int nvec = 0, nbad = 0, viol = 0;
  logic [7:0] mdl [NR];
  logic oe_d = 1'b0;

  always @(negedge clk) begin
    if (rst_n && scl_h && (sda_oe != oe_d)) viol++;
    oe_d <= sda_oe;
  end

  function automatic logic [7:0] minc(input logic [7:0] i);
    return (i == 8'(NR - 1)) ? 8'd0 : i + 8'd1;
  endfunction

  function automatic logic [7:0] mrd(input logic [7:0] i);
    return (i < 8'(NR)) ? mdl[i[2:0]] : 8'h00;
  endfunction

  function automatic logic [NR*8-1:0] pk();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq();
  endtask

  task automatic wbits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0;
    end
    wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0;
    end
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq();
    ack = ~sda_line;
    scl_h = 1'b0; wq();
  endtask

  task automatic rbyte(input bit last, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_h = 1'b1; wq();
      b = {b[6:0], sda_line};
      scl_h = 1'b0;
    end
    sda_h = last; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0; wq();
    sda_h = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b, p, d;
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(regs_o == '0, "R9 regs", regs_o, 0);
    chk(sda_oe == 1'b0, "R9 sda", sda_oe, 0);
    rst_n = 1'b1;
    wq();

    for (int n = 0; n < 10; n++) begin
      for (int x = 1; x <= 3; x++) begin
        bstart();
        wbyte(8'hD4, a); chk(a, "R1 write addr ack", a, 1);
        wbyte(8'(n), a); chk(a, "R2 index ack", a, 1);
        wbyte(8'(x), a); chk(a, "R2 count ack", a, 1);
        p = 8'(n);
        for (int k = 0; k <= x; k++) begin
          d = 8'(n * 37 + k * 11 + x * 5) ^ 8'hA5;
          wbyte(d, a);
          if (k < x) begin
            chk(a, "R2 data ack", a, 1);
            if (p < 8'(NR)) mdl[p[2:0]] = d;
            p = minc(p);
          end else begin
            chk(a, "R3 extra ack", a, 1);
          end
        end
        bstop();
        chk(regs_o == pk(), "R2 R3 R4 bank after write", regs_o, pk());
      end
    end

    for (int n = 0; n < 10; n++) begin
      bstart();
      wbyte(8'hD4, a); chk(a, "R1 addr ack", a, 1);
      wbyte(8'(n), a); chk(a, "R2 index ack", a, 1);
      bstart();
      wbyte(8'hD5, a); chk(a, "R5 read addr ack", a, 1);
      rbyte(1'b0, b); chk(b == mdl[CI], "R5 count byte", b, mdl[CI]);
      p = 8'(n);
      for (int k = 0; k < 3; k++) begin
        rbyte(k == 2, b);
        chk(b == mrd(p), "R5 R4 read data", b, mrd(p));
        p = minc(p);
      end
      chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
      scl_h = 1'b1; wq(); scl_h = 1'b0; wq(); scl_h = 1'b1; wq();
      chk(sda_oe == 1'b0, "R6 idle after nack", sda_oe, 0);
      scl_h = 1'b0; wq();
      bstop();
    end

    for (int j = 0; j < 4; j++) begin
      d = (j == 0) ? 8'hA0 : (j == 1) ? 8'hD6 : (j == 2) ? 8'h54 : 8'hD0;
      bstart();
      wbyte(d, a); chk(!a, "R1 foreign addr nack", a, 0);
      wbyte(8'h02, a); chk(!a, "R1 stays released", a, 0);
      wbyte(8'h01, a); chk(!a, "R1 stays released", a, 0);
      wbyte(8'hEE, a);
      bstop();
      chk(regs_o == pk(), "R1 bank untouched", regs_o, pk());
    end

    bstart();
    wbyte(8'hD4, a); wbyte(8'h03, a); wbyte(8'h02, a);
    wbits(8'h0F, 4);
    bstart();
    wbyte(8'hD4, a); chk(a, "R7 ack after restart abort", a, 1);
    wbyte(8'h05, a); wbyte(8'h01, a); wbyte(8'h3C, a);
    bstop();
    mdl[5] = 8'h3C;
    chk(regs_o == pk(), "R7 partial byte dropped", regs_o, pk());

    bstart();
    wbyte(8'hD4, a); wbyte(8'h01, a); wbyte(8'h01, a);
    wbits(8'h55, 3);
    bstop();
    chk(regs_o == pk(), "R7 stop abort", regs_o, pk());
    bstart();
    wbyte(8'hD4, a); chk(a, "R7 ack after stop abort", a, 1);
    wbyte(8'h01, a); wbyte(8'h01, a); wbyte(8'h77, a);
    bstop();
    mdl[1] = 8'h77;
    chk(regs_o == pk(), "R7 write after abort", regs_o, pk());

    chk(viol == 0, "R8 enable change while clock high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule